// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. Software starts a conversion by raising a busy bit. The sequencer then walks a trial code through a digital-to-analog path and reads back one comparator decision for each conversion period. When the last bit is settled, it loads the code into a pair of 8-bit result registers, drops the busy bit and raises an interrupt flag.

The conversion period is either the system clock divided by 16, 32 or 64, or a fixed number of pulses from a separate tick source that runs independently of the system clock. A conversion always spans eleven periods. The first period is a settling slot, and each of the following ten periods decides one bit. Every bit is decided at the midpoint of its period, so the tenth bit is already final for the whole second half of the last period. Software may stop a conversion early. A stop that lands in that final half period keeps a full, valid result. Any earlier stop throws the conversion away.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy`, `irq_flag`, `res_hi` and `res_lo` are all zero.
- R2: With a system-clock source, `busy` stays high for exactly 11 × divisor clock cycles after the cycle in which `start` is sampled.
- R3: `clk_sel` encoding: 0 selects divide-by-16, 1 selects divide-by-32, 2 selects divide-by-64, and 3 selects one conversion period per `DED_DIV` pulses of `ded_tick`. The selection is captured when the conversion starts.
- R4: On normal completion, `busy` clears, `irq_flag` sets and the result registers load, all on the same clock edge.
- R5: When `just_left`=1, `res_hi` = code[9:2] and `res_lo` = {code[1:0], 6'b0}. When `just_left`=0, `res_hi` = {6'b0, code[9:8]} and `res_lo` = code[7:0].
- R6: An `abort` pulse before the midpoint of the last period ends the conversion on the next edge. The result registers keep their previous value and `irq_flag` does not set.
- R7: An `abort` pulse in the second half of the last period ends the conversion on the next edge. The result is valid and `irq_flag` sets.
- R8: `irq_flag` stays set until `irq_clr` is high. If a completion happens in the same cycle as `irq_clr`, the flag stays set.
- R9: A `start` pulse while `busy` is high is ignored. The running conversion keeps its length and its result.
- R10: Bits are resolved MSB first. Each period sets its trial bit on `dac_code`, and at the period's midpoint the bit is kept if `cmp_in`=1 (input at or above the trial code) or cleared if `cmp_in`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (sets busy) |
| abort | input | 1 | Software stop of a running conversion |
| clk_sel | input | 2 | Conversion-period source select |
| ded_tick | input | 1 | Pulse from the independent conversion clock |
| just_left | input | 1 | Result placement: 1 left, 0 right |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| irq_clr | input | 1 | Clear the interrupt flag |
| dac_code | output | 10 | Trial code driven to the converter's DAC |
| busy | output | 1 | Conversion running (GO/DONE state) |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| res_hi | output | 8 | Upper result register |
| res_lo | output | 8 | Lower result register |

## Verification
The comparator is modelled as a compare of the trial code against a target level, so every finished conversion must return that level exactly. Targets of alternating ones and zeros in both phases, all ones, all zeros and odd mixed codes catch a stuck or swapped bit decision. Each conversion runs under a different period source and justification, and the measured busy length tells the divisors apart. A stop placed mid-conversion and a stop placed just after the last midpoint separate the discard path from the late-stop path, and a restart attempt during a run shows whether the sequencer can be restarted while busy.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Conversion-period source; the encoding is visible on the clk_sel port.
    typedef enum logic [1:0] {
        SRC_DIV16     = 2'd0,
        SRC_DIV32     = 2'd1,
        SRC_DIV64     = 2'd2,
        SRC_DEDICATED = 2'd3
    } clk_src_e;

    // Periods spent before the first bit decision.
    localparam int SETUP_SLOTS = 1;

    // Largest system-clock divisor offered.
    localparam int MAX_SYS_DIV = 64;

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen #(
    parameter int DED_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  sar_pkg::clk_src_e src,
    input  logic              ded_tick,
    output logic              half_tick,
    output logic              end_tick
);
    import sar_pkg::*;

    localparam int MAXD  = (DED_DIV > MAX_SYS_DIV) ? DED_DIV : MAX_SYS_DIV;
    localparam int CNT_W = $clog2(MAXD);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_d, mid_d;
    logic             step;

    always_comb begin
        case (src)
            SRC_DIV16: begin last_d = CNT_W'(15); mid_d = CNT_W'(7);  end
            SRC_DIV32: begin last_d = CNT_W'(31); mid_d = CNT_W'(15); end
            SRC_DIV64: begin last_d = CNT_W'(63); mid_d = CNT_W'(31); end
            default:   begin last_d = CNT_W'(DED_DIV - 1); mid_d = CNT_W'(DED_DIV / 2 - 1); end
        endcase
        step      = (src == SRC_DEDICATED) ? ded_tick : 1'b1;
        half_tick = run && step && (cnt_q == mid_d);
        end_tick  = run && step && (cnt_q == last_d);

        cnt_d = cnt_q;
        if (!run)          cnt_d = '0;
        else if (end_tick) cnt_d = '0;
        else if (step)     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !(half_tick && end_tick));                       // R3

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));                                 // R2

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  sar_pkg::clk_src_e src_in,
    input  logic              cmp_in,
    input  logic              half_tick,
    input  logic              end_tick,
    input  logic              irq_clr,
    output logic              busy,
    output sar_pkg::clk_src_e src_q,
    output logic [RES_W-1:0]  code,
    output logic [RES_W-1:0]  result,
    output logic              irq
);
    import sar_pkg::*;

    localparam int LAST_SLOT = RES_W + SETUP_SLOTS - 1;
    localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
    localparam int IDX_W     = $clog2(RES_W + 1);

    typedef struct packed {
        logic             busy;
        logic             last_half;
        logic [SLOT_W-1:0] slot;
        logic [RES_W-1:0] code;
        logic [RES_W-1:0] result;
        logic             irq;
        clk_src_e         src;
    } st_t;

    st_t        st_d, st_q;
    logic       done, discard;
    logic [IDX_W-1:0] dec_idx, trial_idx;

    always_comb begin
        st_d      = st_q;
        done      = 1'b0;
        discard   = 1'b0;
        dec_idx   = IDX_W'(LAST_SLOT - int'(st_q.slot));
        trial_idx = IDX_W'(LAST_SLOT - 1 - int'(st_q.slot));

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy      = 1'b1;
                st_d.last_half = 1'b0;
                st_d.slot      = '0;
                st_d.code      = '0;
                st_d.src       = src_in;
            end
        end else begin
            if (half_tick && (st_q.slot >= SLOT_W'(SETUP_SLOTS))) begin
                st_d.code[dec_idx] = cmp_in;
                if (st_q.slot == SLOT_W'(LAST_SLOT)) st_d.last_half = 1'b1;
            end
            if (end_tick) begin
                if (st_q.slot == SLOT_W'(LAST_SLOT)) begin
                    done = 1'b1;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                    if (st_q.slot >= SLOT_W'(SETUP_SLOTS - 1))
                        st_d.code[trial_idx] = 1'b1;
                end
            end
            if (!done && abort) begin
                if (st_q.last_half) done    = 1'b1;
                else                discard = 1'b1;
            end
            if (done) begin
                st_d.busy   = 1'b0;
                st_d.result = st_d.code;
            end
            if (discard) st_d.busy = 1'b0;
        end

        if (irq_clr) st_d.irq = 1'b0;
        if (done)    st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, last_half: 1'b0, slot: '0, code: '0,
                              result: '0, irq: 1'b0, src: SRC_DIV16};
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign src_q  = st_q.src;
    assign code   = st_q.code;
    assign result = st_q.result;
    assign irq    = st_q.irq;

    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.slot <= SLOT_W'(LAST_SLOT)));        // R2

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (irq && !busy));                                // R4

    AST_DISCARD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> ($stable(result) && !busy));                 // R6

    AST_LATE_STOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort && st_q.last_half) |=> (irq && !busy));   // R7

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !done) |=> !irq);                            // R8

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && !discard) |=> (busy && $stable(src_q))); // R9

endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic [RES_W-1:0] value,
    input  logic             left,
    output logic [REG_W-1:0] hi,
    output logic [REG_W-1:0] lo
);
    localparam int PAD_W = 2 * REG_W - RES_W;

    logic [2*REG_W-1:0] packed_v;

    always_comb begin
        packed_v = left ? {value, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, value};
        hi       = packed_v[2*REG_W-1:REG_W];
        lo       = packed_v[REG_W-1:0];
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int RES_W   = 10,
    parameter int REG_W   = 8,
    parameter int DED_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [1:0]       clk_sel,
    input  logic             ded_tick,
    input  logic             just_left,
    input  logic             cmp_in,
    input  logic             irq_clr,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             irq_flag,
    output logic [REG_W-1:0] res_hi,
    output logic [REG_W-1:0] res_lo
);
    import sar_pkg::*;

    clk_src_e         src_run;
    logic             half_tick, end_tick;
    logic [RES_W-1:0] result;

    sar_ctrl #(.RES_W(RES_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .src_in    (clk_src_e'(clk_sel)),
        .cmp_in    (cmp_in),
        .half_tick (half_tick),
        .end_tick  (end_tick),
        .irq_clr   (irq_clr),
        .busy      (busy),
        .src_q     (src_run),
        .code      (dac_code),
        .result    (result),
        .irq       (irq_flag)
    );

    sar_tad_gen #(.DED_DIV(DED_DIV)) tad_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .src       (src_run),
        .ded_tick  (ded_tick),
        .half_tick (half_tick),
        .end_tick  (end_tick)
    );

    sar_fmt #(.RES_W(RES_W), .REG_W(REG_W)) fmt_i (
        .value (result),
        .left  (just_left),
        .hi    (res_hi),
        .lo    (res_lo)
    );

endmodule

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DED_DIV    = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start = 1'b0, abort = 1'b0, irq_clr = 1'b0;
    logic       just_left = 1'b0, ded_tick = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [9:0] vin = '0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       busy, irq_flag;
    logic [7:0] res_hi, res_lo;

    int checks = 0, errors = 0;
    logic [9:0] last_v = '0;

    typedef struct { logic [9:0] v; string req; } exp_t;
    exp_t exp_q[$];

    assign cmp_in = (dac_code <= vin);   // R10 comparator model

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_seq_top #(.DED_DIV(DED_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .clk_sel(clk_sel), .ded_tick(ded_tick), .just_left(just_left),
        .cmp_in(cmp_in), .irq_clr(irq_clr), .dac_code(dac_code),
        .busy(busy), .irq_flag(irq_flag), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] fmt(logic [9:0] v, bit left);
        return left ? {v, 6'b0} : {6'b0, v};
    endfunction

    // Independent conversion clock: one pulse every three system cycles.
    initial forever begin
        repeat (2) @(negedge clk);
        ded_tick = 1'b1;
        @(negedge clk);
        ded_tick = 1'b0;
    end

    // Monitor: pops the expected code at each rising completion flag.
    initial begin
        bit seen = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && irq_flag && !seen) begin
                if (exp_q.size() == 0) check("R4", "unexpected completion", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    check(e.req, "result", {res_hi, res_lo}, fmt(e.v, just_left));
                end
                seen = 1'b1;
            end else if (!irq_flag) seen = 1'b0;
        end
    end

    task automatic conv(input logic [9:0] v, input logic [1:0] sel, input bit left,
                        input int abort_at, input int restart_at, input string req);
        int  div;
        int  n;
        bit  late;
        div  = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 32 : (sel == 2'd2) ? 64 : 0;
        n    = 0;
        late = (abort_at != 0) && (abort_at > 10 * div + div / 2);
        vin = v; clk_sel = sel; just_left = left;
        if (abort_at == 0 || late) exp_q.push_back('{v, req});
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy) begin
            n++;
            abort = (n == abort_at);
            start = (n == restart_at);
            @(negedge clk);
        end
        abort = 1'b0; start = 1'b0;
        if (abort_at != 0 && !late) begin
            check("R6", "busy cycles", n, abort_at);
            check("R6", "irq after discard", irq_flag, 0);
            check("R6", "kept result", {res_hi, res_lo}, fmt(last_v, left));
        end else begin
            check("R4", "irq after completion", irq_flag, 1);
            last_v = v;
            if (late)              check("R7", "busy cycles", n, abort_at);
            else if (div == 0)     check("R3", "dedicated length in window",
                                         (n >= 11*DED_DIV*3 - 4) && (n <= 11*DED_DIV*3 + 3), 1);
            else if (restart_at)   check("R9", "busy cycles", n, 11 * div);
            else                   check("R2", "busy cycles", n, 11 * div);
            just_left = !left;
            @(negedge clk);
            check("R5", "swapped placement", {res_hi, res_lo}, fmt(v, !left));
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            check("R8", "irq cleared", irq_flag, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R2 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1", "busy at reset", busy, 0);
        check("R1", "irq at reset", irq_flag, 0);
        check("R1", "result at reset", {res_hi, res_lo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        conv(10'h2AA, 2'd0, 1'b0, 0, 0, "R10");
        conv(10'h155, 2'd1, 1'b1, 0, 0, "R10");
        conv(10'h3FF, 2'd2, 1'b0, 0, 0, "R10");
        conv(10'h000, 2'd0, 1'b1, 0, 0, "R10");
        conv(10'h201, 2'd3, 1'b0, 0, 0, "R3");
        conv(10'h0F0, 2'd0, 1'b0, 80, 0, "R6");
        conv(10'h1C3, 2'd0, 1'b1, 170, 0, "R7");
        conv(10'h37A, 2'd1, 1'b0, 0, 50, "R9");

        check("R4", "all completions seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule